// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Checker

This block sits next to the retire stage of a small in-order 32-bit core and enforces forward-edge control-flow integrity. It watches each retired instruction. When a register-indirect jump that is subject to tracking retires, the block sets a pending flag. The next instruction to retire must then be a landing-pad marker. A valid marker is correctly encoded, sits at a word-aligned address, and carries a label that agrees with register x7 whenever the label is non-zero. Any breach produces a single-cycle trap request with a fixed cause code and trap value.

The core supplies the retired instruction word, its address and the current value of x7. It also reports when a trap is actually taken. The block does no decoding beyond the few fields it needs, and it has no register file of its own. An enable input turns the whole check on or off.

Top module: `lpad_guard`

## Requirements
- R1: After reset, `trap_req` is 0, `trap_cause` and `trap_tval` are 0, and `pad_pending` is 0.
- R2: With `chk_en` high, retiring a jump-and-link-register instruction sets `pad_pending` on the next clock edge. Such an instruction has opcode bits [6:0]=1100111 and funct3 bits [14:12]=000. The flag is set only when the base register field, bits [19:15], is not 1, 5 or 7. Every other instruction, including other funct3 values and the direct jump, leaves the flag clear.
- R3: `pad_pending` holds its value through cycles with `ret_valid` low. It is cleared by the next retired instruction.
- R4: A landing-pad marker is opcode 0010111 with destination bits [11:7]=0. A marker retired while pending, at an address with bits [1:0]=00 and a zero label (bits [31:12]), raises no trap. An instruction with that opcode and a non-zero destination is not a marker.
- R5: A retired instruction that is not a marker, arriving while pending, raises a trap.
- R6: A marker retired while pending at an address with bits [1:0] not 00 raises a trap.
- R7: A marker with a non-zero label raises a trap unless the label equals bits [31:12] of `x7_val` in the same cycle. The low bits of x7 are ignored.
- R8: A trap request is a `trap_req` pulse one cycle wide, driven on the edge after the offending retire, with `trap_cause`=18 and `trap_tval`=2. Both of these outputs read 0 whenever `trap_req` is low.
- R9: While `chk_en` is low, nothing is armed, `pad_pending` is cleared and no trap is raised.
- R10: `trap_taken` clears `pad_pending`, and it stops a jump retiring in the same cycle from arming.
- R11: A retired instruction that raises a trap does not arm the flag, even when it is itself a tracked jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Enables tracking and checking |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_insn | input | 32 | Retired instruction word |
| ret_pc | input | XLEN | Address of the retired instruction |
| x7_val | input | XLEN | Current value of x7 |
| trap_taken | input | 1 | The core is taking a trap this cycle |
| pad_pending | output | 1 | A landing pad is expected next |
| trap_req | output | 1 | Violation trap request pulse |
| trap_cause | output | XLEN | Trap cause code while `trap_req` is high |
| trap_tval | output | XLEN | Trap value while `trap_req` is high |

## Verification
The assertions assume the core acknowledges a trap request and that `ret_valid`, `ret_insn`, `ret_pc` and `x7_val` are settled before each rising edge. They also assume `trap_taken` may arrive in any cycle, independently of `trap_req`. The bench changes inputs only on the falling edge. It drives `trap_taken` only in the cycles chosen to test R10, so every violation pulse it expects comes from the retire stream alone.

// File: rtl/lpad_guard.sv
module lpad_guard #(
  parameter int XLEN       = 32,
  parameter int LABEL_W    = 20,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2,
  parameter int LINK_A     = 1,
  parameter int LINK_B     = 5,
  parameter int GUARD_REG  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic            ret_valid,
  input  logic [31:0]     ret_insn,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [XLEN-1:0] x7_val,
  input  logic            trap_taken,
  output logic            pad_pending,
  output logic            trap_req,
  output logic [XLEN-1:0] trap_cause,
  output logic [XLEN-1:0] trap_tval
);

  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_AUIPC = 7'b0010111;
  localparam int         LBL_LSB  = XLEN - LABEL_W;
  localparam int         IMM_LSB  = 32 - LABEL_W;

  wire [6:0]         opc   = ret_insn[6:0];
  wire [4:0]         rd    = ret_insn[11:7];
  wire [2:0]         fn3   = ret_insn[14:12];
  wire [4:0]         rs1   = ret_insn[19:15];
  wire [LABEL_W-1:0] label = ret_insn[31:IMM_LSB];
  wire [LABEL_W-1:0] want  = x7_val[XLEN-1:LBL_LSB];

  wire exempt   = (rs1 == 5'(LINK_A)) || (rs1 == 5'(LINK_B)) || (rs1 == 5'(GUARD_REG));
  wire tracked  = (opc == OP_JALR) && (fn3 == 3'b000) && !exempt;
  wire is_pad   = (opc == OP_AUIPC) && (rd == 5'd0);
  wire misalign = |ret_pc[1:0];
  wire bad_lbl  = (label != '0) && (label != want);

  wire checking  = chk_en && ret_valid && pad_pending;
  wire violation = checking && (!is_pad || misalign || bad_lbl);
  wire arm       = chk_en && ret_valid && tracked && !violation && !trap_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_pending <= 1'b0;
      trap_req    <= 1'b0;
      trap_cause  <= '0;
      trap_tval   <= '0;
    end else begin
      if (!chk_en || trap_taken)
        pad_pending <= 1'b0;
      else if (ret_valid)
        pad_pending <= arm;
      trap_req   <= violation;
      trap_cause <= violation ? XLEN'(CAUSE_CODE) : '0;
      trap_tval  <= violation ? XLEN'(TVAL_CODE)  : '0;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req); // R8
  AST_TRAP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause == XLEN'(CAUSE_CODE)) && (trap_tval == XLEN'(TVAL_CODE))); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_cause == '0) && (trap_tval == '0)); // R8
  AST_TRAP_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(pad_pending && ret_valid)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !trap_req && !pad_pending); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pending && !ret_valid && chk_en && !trap_taken |=> pad_pending); // R3
  AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> !pad_pending); // R10
  AST_TRAP_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !pad_pending); // R11

endmodule

// File: tb/lpad_guard_test.sv
`timescale 1ns/1ps
module lpad_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_en = 1'b0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_insn = 32'h13;
  logic [31:0] ret_pc = '0;
  logic [31:0] x7_val = '0;
  logic        trap_taken = 1'b0;
  logic        pad_pending, trap_req;
  logic [31:0] trap_cause, trap_tval;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lpad_guard uut (.clk(clk), .rst_n(rst_n), .chk_en(chk_en), .ret_valid(ret_valid),
    .ret_insn(ret_insn), .ret_pc(ret_pc), .x7_val(x7_val), .trap_taken(trap_taken),
    .pad_pending(pad_pending), .trap_req(trap_req), .trap_cause(trap_cause),
    .trap_tval(trap_tval));

  function automatic logic [31:0] jalr(input logic [4:0] r, input logic [2:0] f = 3'b000);
    return {12'h0, r, f, 5'd0, 7'b1100111};
  endfunction
  function automatic logic [31:0] lpad(input logic [19:0] imm, input logic [4:0] rd = 5'd0);
    return {imm, rd, 7'b0010111};
  endfunction
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] JAL = 32'h0000_00EF;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] insn, input logic [31:0] pc = 32'h100,
                      input logic [31:0] x7 = 32'h0, input logic en = 1'b1, input logic tt = 1'b0);
    @(negedge clk);
    ret_valid = v; ret_insn = insn; ret_pc = pc; x7_val = x7; chk_en = en; trap_taken = tt;
    @(posedge clk);
    #1;
  endtask

  task automatic arm();
    step(1, jalr(5'd10));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pending", {31'b0, pad_pending}, 0);
    check("R1 trap", {31'b0, trap_req}, 0);
    check("R1 cause", trap_cause, 0);
    check("R1 tval", trap_tval, 0);
    @(negedge clk); rst_n = 1'b1; chk_en = 1'b1;

    for (int r = 0; r < 32; r++) begin
      step(1, jalr(5'(r)));
      check($sformatf("R2 rs1=%0d", r), {31'b0, pad_pending}, (r == 1 || r == 5 || r == 7) ? 0 : 1);
      step(1, lpad(20'h0), 32'h200);
      check("R4 clean marker trap", {31'b0, trap_req}, 0);
      check("R3 cleared", {31'b0, pad_pending}, 0);
    end
    for (int f = 1; f < 8; f++) begin
      step(1, jalr(5'd10, 3'(f)));
      check("R2 funct3", {31'b0, pad_pending}, 0);
    end
    step(1, JAL);
    check("R2 direct jump", {31'b0, pad_pending}, 0);

    arm();
    for (int i = 0; i < 5; i++) begin
      step(0, NOP);
      check("R3 hold", {31'b0, pad_pending}, 1);
    end
    step(1, NOP);
    check("R5 trap", {31'b0, trap_req}, 1);
    check("R8 cause", trap_cause, 18);
    check("R8 tval", trap_tval, 2);
    step(0, NOP);
    check("R8 one cycle", {31'b0, trap_req}, 0);
    check("R8 cause idle", trap_cause, 0);

    arm();
    step(1, lpad(20'h0, 5'd3));
    check("R4 rd nonzero", {31'b0, trap_req}, 1);

    for (int a = 0; a < 4; a++) begin
      arm();
      step(1, lpad(20'h0), 32'h400 + 32'(a));
      check($sformatf("R6 align=%0d", a), {31'b0, trap_req}, (a != 0) ? 1 : 0);
    end

    begin
      logic [19:0] vals [5] = '{20'h0, 20'h1, 20'h80000, 20'hFFFFF, 20'h12345};
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          arm();
          step(1, lpad(vals[i]), 32'h800, {vals[j], 12'hA5C});
          check($sformatf("R7 imm=%h x7=%h", vals[i], vals[j]), {31'b0, trap_req},
                (vals[i] != 0 && vals[i] != vals[j]) ? 1 : 0);
        end
    end

    step(1, jalr(5'd10), 32'h100, 0, 1'b0);
    check("R9 no arm", {31'b0, pad_pending}, 0);
    arm();
    step(1, NOP, 32'h100, 0, 1'b0);
    check("R9 no trap", {31'b0, trap_req}, 0);
    check("R9 cleared", {31'b0, pad_pending}, 0);

    arm();
    step(0, NOP, 32'h100, 0, 1'b1, 1'b1);
    check("R10 cleared", {31'b0, pad_pending}, 0);
    step(1, NOP);
    check("R10 no trap after", {31'b0, trap_req}, 0);
    step(1, jalr(5'd10), 32'h100, 0, 1'b1, 1'b1);
    check("R10 no arm", {31'b0, pad_pending}, 0);

    arm();
    step(1, jalr(5'd12));
    check("R11 trap", {31'b0, trap_req}, 1);
    check("R11 not armed", {31'b0, pad_pending}, 0);

    summary();
  end
endmodule